// File: doc/BRIEF.md
# Port Detection and Classification Event Register

This block keeps a sticky event word for a four-port power-sourcing controller. Each port has two flags. One flag marks a finished detection cycle and the other a finished classification cycle. The measurement logic reports each finished cycle as a one-cycle strobe together with a 4-bit result code. The block then sets the matching flag. It does this either on every finished cycle or only when the code differs from the code last recorded for that port. A separate mode bit picks this behaviour for detection and another picks it for classification.

Software reads the word through a small read port that accepts two command codes:

- The first command returns the word and leaves it unchanged.
- The second command returns the same word and then clears it.

Powering a port down clears both of that port's flags. The block also drives a level output toward an interrupt aggregator. That output is high whenever any flag is set.

Top module: `dc_event_reg`

## Requirements
- R1: After reset all eight flags are 0, `evt_pending` is low, and every port's stored detection and class codes are 0.
- R2: Flag layout. Bit p (p = 0..3) is the detection flag of port p+1. Bit 4+p is the classification flag of port p+1.
- R3: A read strobe with command 8'h04 returns the flag word on `rd_data` in the same cycle, raises `rd_hit`, and leaves the word unchanged.
- R4: A read strobe with command 8'h05 returns the flag word in the same cycle and raises `rd_hit`. At the next clock edge it clears every flag that has no new event in that cycle.
- R5: With the matching mode bit low (0), every detection or classification strobe on a port sets that port's flag at the next edge.
- R6: With the matching mode bit high (1), a strobe sets the flag only if its code differs from the port's stored code. Every strobe updates the stored code, whatever the mode.
- R7: `port_off[p]` clears both flags of port p+1 at the next edge. It takes priority over an event on that port in the same cycle. It leaves the stored codes alone.
- R8: An event arriving in the same cycle as a clear-on-read sets its flag, so the flag is 1 after that edge.
- R9: A read strobe with any other command changes no flag, keeps `rd_hit` low and keeps `rd_data` at 0.
- R10: `evt_pending` is high exactly when at least one flag is set.
- R11: A flag set to 1 stays 1 until a clear-on-read, a port-off or reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| det_done | input | 4 | Per-port detection-finished strobe |
| det_code | input | 16 | Per-port 4-bit detection result, port p in bits 4p+3:4p |
| cls_done | input | 4 | Per-port classification-finished strobe |
| cls_code | input | 16 | Per-port 4-bit class code, port p in bits 4p+3:4p |
| port_off | input | 4 | Per-port power-off indication |
| det_chg_mode | input | 1 | 1: detection flags report changes only |
| cls_chg_mode | input | 1 | 1: classification flags report changes only |
| rd_stb | input | 1 | Read strobe |
| rd_cmd | input | 8 | Read command code |
| rd_data | output | 8 | Flag word when `rd_hit`, else 0 |
| rd_hit | output | 1 | Command addressed this register |
| evt_pending | output | 1 | Any flag set |

## Verification
The bench drives random strobes with codes drawn from a small set, so repeated and changed codes both occur often. This separates the any-cycle mode from the change-only mode and shows that stored codes update in both modes. Random read commands mix the peek command, the clear command and unrelated codes. These tell a non-destructive read apart from a clearing read and from a read this register should ignore. Directed cases then place a clear-on-read and a port-off in the same cycle as a new event, to confirm which one wins.

// File: rtl/dcev_pkg.sv
package dcev_pkg;

  // Does a finished cycle produce a flag event?
  function automatic logic evt_fire(input logic done, input logic chg_mode,
                                    input logic [3:0] new_code,
                                    input logic [3:0] old_code);
    return done && (!chg_mode || (new_code != old_code));
  endfunction

  // Next value of one sticky flag; port-off wins, then new event, then clear.
  function automatic logic flag_next(input logic cur, input logic set_evt,
                                     input logic off, input logic take);
    if (off)          return 1'b0;
    else if (set_evt) return 1'b1;
    else if (take)    return 1'b0;
    else              return cur;
  endfunction

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_PEEK = 2'd1,
    RD_TAKE = 2'd2
  } rd_kind_e;

endpackage

// File: rtl/dcev_port_track.sv
module dcev_port_track
  import dcev_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det_done,
  input  logic [CODE_W-1:0] det_code,
  input  logic              cls_done,
  input  logic [CODE_W-1:0] cls_code,
  input  logic              det_chg_mode,
  input  logic              cls_chg_mode,
  output logic              det_evt,
  output logic              cls_evt
);

  logic [CODE_W-1:0] last_det_q;
  logic [CODE_W-1:0] last_cls_q;

  always_comb begin
    det_evt = evt_fire(det_done, det_chg_mode, 4'(det_code), 4'(last_det_q));
    cls_evt = evt_fire(cls_done, cls_chg_mode, 4'(cls_code), 4'(last_cls_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_det_q <= '0;
      last_cls_q <= '0;
    end else begin
      if (det_done) last_det_q <= det_code;
      if (cls_done) last_cls_q <= cls_code;
    end
  end

endmodule

// File: rtl/dcev_flag_bank.sv
module dcev_flag_bank
  import dcev_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_vec,
  input  logic [WIDTH-1:0] off_vec,
  input  logic             take,
  output logic [WIDTH-1:0] flags
);

  logic [WIDTH-1:0] flags_d;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb flags_d[i] = flag_next(flags[i], set_vec[i], off_vec[i], take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

endmodule

// File: rtl/dcev_cmd_decode.sv
module dcev_cmd_decode
  import dcev_pkg::*;
#(
  parameter int          CMD_W    = 8,
  parameter logic [7:0]  CMD_PEEK = 8'h04,
  parameter logic [7:0]  CMD_TAKE = 8'h05
) (
  input  logic             rd_stb,
  input  logic [CMD_W-1:0] rd_cmd,
  output rd_kind_e         kind
);

  always_comb begin
    kind = RD_NONE;
    if (rd_stb) begin
      if (rd_cmd == CMD_W'(CMD_PEEK))      kind = RD_PEEK;
      else if (rd_cmd == CMD_W'(CMD_TAKE)) kind = RD_TAKE;
    end
  end

endmodule

// File: rtl/dc_event_reg.sv
module dc_event_reg
  import dcev_pkg::*;
#(
  parameter int          NUM_PORTS = 4,
  parameter int          CODE_W    = 4,
  parameter int          CMD_W     = 8,
  parameter logic [7:0]  CMD_PEEK  = 8'h04,
  parameter logic [7:0]  CMD_TAKE  = 8'h05,
  localparam int         REG_W     = 2 * NUM_PORTS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        det_done,
  input  logic [NUM_PORTS*CODE_W-1:0] det_code,
  input  logic [NUM_PORTS-1:0]        cls_done,
  input  logic [NUM_PORTS*CODE_W-1:0] cls_code,
  input  logic [NUM_PORTS-1:0]        port_off,
  input  logic                        det_chg_mode,
  input  logic                        cls_chg_mode,
  input  logic                        rd_stb,
  input  logic [CMD_W-1:0]            rd_cmd,
  output logic [REG_W-1:0]            rd_data,
  output logic                        rd_hit,
  output logic                        evt_pending
);

  // Named internal events, visible to the bound checker.
  logic [NUM_PORTS-1:0] det_evt;
  logic [NUM_PORTS-1:0] cls_evt;
  logic [REG_W-1:0]     set_vec;
  logic [REG_W-1:0]     off_vec;
  logic [REG_W-1:0]     flags;
  logic                 take_now;
  rd_kind_e             rd_kind;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    dcev_port_track #(.CODE_W(CODE_W)) u_track (
      .clk          (clk),
      .rst_n        (rst_n),
      .det_done     (det_done[p]),
      .det_code     (det_code[p*CODE_W +: CODE_W]),
      .cls_done     (cls_done[p]),
      .cls_code     (cls_code[p*CODE_W +: CODE_W]),
      .det_chg_mode (det_chg_mode),
      .cls_chg_mode (cls_chg_mode),
      .det_evt      (det_evt[p]),
      .cls_evt      (cls_evt[p])
    );
  end

  // Detection flags occupy the low half, classification the high half.
  assign set_vec = {cls_evt, det_evt};
  assign off_vec = {port_off, port_off};

  dcev_cmd_decode #(
    .CMD_W    (CMD_W),
    .CMD_PEEK (CMD_PEEK),
    .CMD_TAKE (CMD_TAKE)
  ) u_dec (
    .rd_stb (rd_stb),
    .rd_cmd (rd_cmd),
    .kind   (rd_kind)
  );

  assign take_now = (rd_kind == RD_TAKE);

  dcev_flag_bank #(.WIDTH(REG_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .off_vec (off_vec),
    .take    (take_now),
    .flags   (flags)
  );

  always_comb begin
    rd_hit  = (rd_kind != RD_NONE);
    rd_data = rd_hit ? flags : '0;
  end

  assign evt_pending = |flags;

endmodule

// File: rtl/dcev_checker.sv
module dcev_checker #(
  parameter int NUM_PORTS = 4,
  localparam int REG_W = 2 * NUM_PORTS
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [REG_W-1:0]     flags,
  input logic [REG_W-1:0]     set_vec,
  input logic [NUM_PORTS-1:0] port_off,
  input logic                 rd_stb,
  input logic [7:0]           rd_cmd,
  input logic [REG_W-1:0]     rd_data,
  input logic                 rd_hit,
  input logic                 evt_pending
);

  logic [REG_W-1:0] off_mask;
  logic             is_peek;
  logic             is_take;
  logic             quiet;

  assign off_mask = {port_off, port_off};
  assign is_peek  = rd_stb && (rd_cmd == 8'h04);
  assign is_take  = rd_stb && (rd_cmd == 8'h05);
  assign quiet    = (set_vec == '0) && (port_off == '0);

  // R3: peek read holds the word when nothing else happens
  a_r3_peek_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (is_peek && quiet) |=> $stable(flags));

  // R4: clear-on-read empties the word when nothing else happens
  a_r4_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (is_take && quiet) |=> (flags == '0));

  // R7: port-off clears that port's flags
  a_r7_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (port_off != '0) |=> ((flags & $past(off_mask)) == '0));

  // R8: an event in the clearing cycle survives
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (is_take && port_off == '0 && set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

  // R9: unrelated commands leave the read bus idle
  a_r9_other_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_peek && !is_take) |-> (!rd_hit && rd_data == '0));

  // R3, R4: a hit returns the current word
  a_r3_hit_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (rd_data == flags));

  // R11: a flag only rises on an event from the previous cycle
  a_r11_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(set_vec)) == '0));

  // R10: pending follows the word
  a_r10_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pending == (flags != '0)));

endmodule

bind dc_event_reg dcev_checker #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flags       (flags),
  .set_vec     (set_vec),
  .port_off    (port_off),
  .rd_stb      (rd_stb),
  .rd_cmd      (rd_cmd),
  .rd_data     (rd_data),
  .rd_hit      (rd_hit),
  .evt_pending (evt_pending)
);

// File: tb/dc_event_reg_bench.sv
module dc_event_reg_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  det_done = '0, cls_done = '0, port_off = '0;
  logic [15:0] det_code = '0, cls_code = '0;
  logic        det_chg_mode = 1'b0, cls_chg_mode = 1'b0;
  logic        rd_stb = 1'b0;
  logic [7:0]  rd_cmd = '0;
  logic [7:0]  rd_data;
  logic        rd_hit, evt_pending;

  int checks = 0;
  int failures = 0;
  bit done_flag = 0;

  logic [7:0] exp_word = '0;
  logic [3:0] ref_det [4];
  logic [3:0] ref_cls [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  dc_event_reg u_dc_event_reg (
    .clk(clk), .rst_n(rst_n), .det_done(det_done), .det_code(det_code),
    .cls_done(cls_done), .cls_code(cls_code), .port_off(port_off),
    .det_chg_mode(det_chg_mode), .cls_chg_mode(cls_chg_mode),
    .rd_stb(rd_stb), .rd_cmd(rd_cmd), .rd_data(rd_data), .rd_hit(rd_hit),
    .evt_pending(evt_pending)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Bench view of a flag that should fire: any cycle, or a changed code.
  function automatic bit fires(bit d, bit chg, logic [3:0] nc, logic [3:0] oc);
    if (!d) return 0;
    if (chg) return nc != oc;
    return 1;
  endfunction

  // Check the combinational read side, clock once, advance the model.
  task automatic step(input string tag);
    bit peek, take;
    logic [7:0] nxt;
    #1;
    peek = rd_stb && rd_cmd == 8'h04;
    take = rd_stb && rd_cmd == 8'h05;
    if (peek || take) begin
      chk(rd_hit == 1'b1, "R3/R4 hit", 32'(rd_hit), 1);
      chk(rd_data == exp_word, (take ? "R4 data" : "R3 data"), 32'(rd_data), 32'(exp_word));
    end else begin
      chk(rd_hit == 1'b0 && rd_data == 8'h00, "R9 idle", 32'(rd_data), 0);
    end
    chk(evt_pending == (exp_word != 0), "R10 pending", 32'(evt_pending), 32'(exp_word != 0));
    nxt = exp_word;
    for (int p = 0; p < 4; p++) begin
      bit fd, fc;
      fd = fires(det_done[p], det_chg_mode, det_code[4*p +: 4], ref_det[p]);
      fc = fires(cls_done[p], cls_chg_mode, cls_code[4*p +: 4], ref_cls[p]);
      if (take) begin nxt[p] = 0; nxt[p+4] = 0; end
      if (fd) nxt[p] = 1;
      if (fc) nxt[p+4] = 1;
      if (port_off[p]) begin nxt[p] = 0; nxt[p+4] = 0; end
      if (det_done[p]) ref_det[p] = det_code[4*p +: 4];
      if (cls_done[p]) ref_cls[p] = cls_code[4*p +: 4];
    end
    @(posedge clk);
    exp_word = nxt;
    @(negedge clk);
    det_done = '0; cls_done = '0; port_off = '0; rd_stb = 0; rd_cmd = '0;
  endtask

  task automatic peek_check(input string req);
    rd_stb = 1; rd_cmd = 8'h04;
    #1;
    chk(rd_data == exp_word, req, 32'(rd_data), 32'(exp_word));
    step(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++) begin ref_det[p] = 0; ref_cls[p] = 0; end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk(evt_pending == 0, "R1 pending", 32'(evt_pending), 0);
    peek_check("R1 word zero");

    // R2 / R5: detection on port 3 -> bit 2; class on port 2 -> bit 5
    det_done = 4'b0100; det_code = 16'h0300;
    cls_done = 4'b0010; cls_code = 16'h0020;
    step("R5");
    chk(exp_word == 8'h24, "R2 model", 32'(exp_word), 32'h24);
    peek_check("R2 layout");
    // R11: sticky over idle cycles
    step("R11"); step("R11");
    peek_check("R11 sticky");
    // R4: clearing read
    rd_stb = 1; rd_cmd = 8'h05; step("R4");
    peek_check("R4 cleared");

    // R6: change mode, same code does not set
    det_chg_mode = 1; det_done = 4'b0100; det_code = 16'h0300; step("R6");
    peek_check("R6 same code");
    det_done = 4'b0100; det_code = 16'h0500; step("R6");
    peek_check("R6 changed code");
    // R8: event during clear-on-read
    rd_stb = 1; rd_cmd = 8'h05; cls_done = 4'b0001; cls_code = 16'h0007;
    step("R8");
    peek_check("R8 event wins");
    // R7: port-off beats event
    port_off = 4'b0001; cls_done = 4'b0001; cls_code = 16'h0009; step("R7");
    peek_check("R7 off clears");
    // R9: other command
    det_chg_mode = 0; det_done = 4'b1000; step("R9 setup");
    rd_stb = 1; rd_cmd = 8'h06; step("R9");
    peek_check("R9 untouched");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      if (($urandom % 50) == 0) det_chg_mode = $urandom % 2;
      if (($urandom % 50) == 0) cls_chg_mode = $urandom % 2;
      for (int p = 0; p < 4; p++) begin
        det_done[p] = ($urandom % 4) == 0;
        cls_done[p] = ($urandom % 4) == 0;
        det_code[4*p +: 4] = 4'($urandom % 3);
        cls_code[4*p +: 4] = 4'($urandom % 3);
        port_off[p] = ($urandom % 20) == 0;
      end
      r = $urandom % 8;
      rd_stb = r < 5;
      rd_cmd = (r < 2) ? 8'h04 : (r < 4) ? 8'h05 : 8'h07;
      step("R5/R6 random");
    end

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule